// File: doc/BRIEF.md
# USB Device State Tracker

This block follows the enumeration progress of a USB device: powered, default, address and configured, plus a suspended form of each. It takes single-cycle event strobes from the protocol layer: bus reset, suspend, resume, SetAddress done and SetConfiguration done. The two completion strobes each come with a flag that marks a zero argument. It drives a 3-bit state code that is registered one clock after the event.

Two sticky status bits are kept. The state-change bit is set by a transition only when that transition's cause enable is high. The enable gates only the status bit and never the transition itself. The resume bit is set whenever a suspended state is left by resume. Each bit is cleared by its own write-one-to-clear strobe.

Top module: `usb_dev_state_trk`

## Requirements
- R1: After reset the state code is 000 (powered) and both status bits are 0.
- R2: Base codes are powered 000, default 001, address 010 and configured 011. A suspended state reads as its base code with bit 2 set (100, 101, 110, 111).
- R3: A bus reset moves the block to 001 from any state, suspended or not. It sets the change bit only if the reset enable is high.
- R4: SetAddress done with a nonzero address, while in 001, moves the block to 010. It sets the change bit only if the address enable is high.
- R5: SetAddress done with address zero, while in 010, moves the block to 001. It sets the change bit only if the reset enable is high.
- R6: SetConfiguration done with a nonzero value, while in 010, moves the block to 011. It sets the change bit only if the configuration enable is high.
- R7: SetConfiguration done with value zero, while in 011, moves the block to 010. It sets the change bit only if the address enable is high.
- R8: Suspend in a non-suspended state sets bit 2 and keeps bits 1:0. It sets the change bit only if the suspend enable is high.
- R9: Resume in a suspended state clears bit 2, which restores the prior state, and sets the resume bit. Resume never sets the change bit.
- R10: A low enable never blocks a state transition.
- R11: Events with no defined transition in the current state leave the state and both status bits unchanged. This covers resume while not suspended, suspend while suspended, and SetAddress or SetConfiguration in any other state or while suspended.
- R12: Same-cycle priority is bus reset first, then suspend or resume, then SetAddress, then SetConfiguration.
- R13: A clear strobe zeroes its status bit on the next clock. A set in the same cycle wins, and the bit stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_reset_i | input | 1 | Bus reset detected strobe |
| suspend_i | input | 1 | Suspend detected strobe |
| resume_i | input | 1 | Resume detected strobe |
| set_addr_i | input | 1 | SetAddress completed strobe |
| addr_zero_i | input | 1 | SetAddress argument is zero |
| set_cfg_i | input | 1 | SetConfiguration completed strobe |
| cfg_zero_i | input | 1 | SetConfiguration value is zero |
| en_reset_i | input | 1 | Change-bit enable for reset-class causes |
| en_addr_i | input | 1 | Change-bit enable for address-class causes |
| en_cfg_i | input | 1 | Change-bit enable for configuration causes |
| en_susp_i | input | 1 | Change-bit enable for suspend |
| clr_chg_i | input | 1 | Write-one-to-clear for the change bit |
| clr_resume_i | input | 1 | Write-one-to-clear for the resume bit |
| state_o | output | 3 | Current device state code |
| chg_irq_o | output | 1 | Sticky state-change status |
| resume_flag_o | output | 1 | Sticky resume status |

## Verification
Every output is a register, so the effect of the inputs driven in one cycle shows exactly one rising edge later. The bench drives inputs on the falling edge. It samples all three outputs on the next falling edge, after the single rising edge, and compares them with a reference model that it advances once per cycle. Random strobes with independent enables reach every state and cause. Directed sequences cover the same-cycle collisions and the clear-versus-set case.

// File: rtl/usb_dev_state_pkg.sv
package usb_dev_state_pkg;
  localparam int unsigned STATE_W = 3;
  localparam int unsigned NUM_FLAGS = 2;
  localparam int unsigned FLAG_CHG = 0;
  localparam int unsigned FLAG_RES = 1;

  typedef enum logic [STATE_W-1:0] {
    ST_POWERED    = 3'b000,
    ST_DEFAULT    = 3'b001,
    ST_ADDRESS    = 3'b010,
    ST_CONFIGURED = 3'b011,
    ST_SUSP_POW   = 3'b100,
    ST_SUSP_DEF   = 3'b101,
    ST_SUSP_ADR   = 3'b110,
    ST_SUSP_CFG   = 3'b111
  } dev_state_e;

  typedef struct packed {
    logic bus_reset;
    logic suspend;
    logic resume;
    logic set_addr;
    logic addr_zero;
    logic set_cfg;
    logic cfg_zero;
  } dev_evt_t;

  typedef struct packed {
    logic reset;
    logic addr;
    logic cfg;
    logic susp;
  } dev_en_t;
endpackage

// File: rtl/usb_dev_state_fsm.sv
module usb_dev_state_fsm
  import usb_dev_state_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  dev_evt_t             evt_i,
  input  dev_en_t              en_i,
  output logic [STATE_W-1:0]   state_o,
  output logic                 chg_set_o,
  output logic                 res_set_o
);
  dev_state_e state_q, state_d;
  logic       susp_q;

  assign susp_q = state_q[STATE_W-1];

  always_comb begin
    state_d   = state_q;
    chg_set_o = 1'b0;
    res_set_o = 1'b0;
    if (evt_i.bus_reset) begin
      state_d   = ST_DEFAULT;
      chg_set_o = en_i.reset;
    end else if (susp_q) begin
      if (evt_i.resume) begin
        state_d   = dev_state_e'({1'b0, state_q[STATE_W-2:0]});
        res_set_o = 1'b1;
      end
    end else if (evt_i.suspend) begin
      state_d   = dev_state_e'({1'b1, state_q[STATE_W-2:0]});
      chg_set_o = en_i.susp;
    end else if (evt_i.set_addr && !evt_i.addr_zero && state_q == ST_DEFAULT) begin
      state_d   = ST_ADDRESS;
      chg_set_o = en_i.addr;
    end else if (evt_i.set_addr && evt_i.addr_zero && state_q == ST_ADDRESS) begin
      state_d   = ST_DEFAULT;
      chg_set_o = en_i.reset;
    end else if (evt_i.set_cfg && !evt_i.cfg_zero && state_q == ST_ADDRESS) begin
      state_d   = ST_CONFIGURED;
      chg_set_o = en_i.cfg;
    end else if (evt_i.set_cfg && evt_i.cfg_zero && state_q == ST_CONFIGURED) begin
      state_d   = ST_ADDRESS;
      chg_set_o = en_i.addr;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_POWERED;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  p_bus_reset_default_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i.bus_reset |=> state_o == ST_DEFAULT);

  p_suspend_keeps_base_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!evt_i.bus_reset && evt_i.suspend && !state_o[2])
      |=> state_o == {1'b1, $past(state_o[1:0])});

  p_resume_restores_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!evt_i.bus_reset && evt_i.resume && state_o[2])
      |=> state_o == {1'b0, $past(state_o[1:0])});

  p_idle_holds_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!evt_i.bus_reset && !evt_i.suspend && !evt_i.resume && !evt_i.set_addr && !evt_i.set_cfg)
      |=> $stable(state_o));

  p_resume_no_chg_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_set_o |-> !chg_set_o);
endmodule

// File: rtl/usb_dev_state_flag.sv
module usb_dev_state_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  p_set_wins_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o);

  p_clear_works_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !q_o);

  p_hold_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !set_i) |=> $stable(q_o));
endmodule

// File: rtl/usb_dev_state_trk.sv
module usb_dev_state_trk
  import usb_dev_state_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_reset_i,
  input  logic               suspend_i,
  input  logic               resume_i,
  input  logic               set_addr_i,
  input  logic               addr_zero_i,
  input  logic               set_cfg_i,
  input  logic               cfg_zero_i,
  input  logic               en_reset_i,
  input  logic               en_addr_i,
  input  logic               en_cfg_i,
  input  logic               en_susp_i,
  input  logic               clr_chg_i,
  input  logic               clr_resume_i,
  output logic [STATE_W-1:0] state_o,
  output logic               chg_irq_o,
  output logic               resume_flag_o
);
  dev_evt_t             evt;
  dev_en_t              en;
  logic [NUM_FLAGS-1:0] flag_set, flag_clr, flag_q;

  assign evt = '{bus_reset: bus_reset_i, suspend: suspend_i, resume: resume_i,
                 set_addr: set_addr_i, addr_zero: addr_zero_i,
                 set_cfg: set_cfg_i, cfg_zero: cfg_zero_i};
  assign en  = '{reset: en_reset_i, addr: en_addr_i, cfg: en_cfg_i, susp: en_susp_i};

  usb_dev_state_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (evt),
    .en_i      (en),
    .state_o   (state_o),
    .chg_set_o (flag_set[FLAG_CHG]),
    .res_set_o (flag_set[FLAG_RES])
  );

  assign flag_clr[FLAG_CHG] = clr_chg_i;
  assign flag_clr[FLAG_RES] = clr_resume_i;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    usb_dev_state_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (flag_set[g]),
      .clr_i  (flag_clr[g]),
      .q_o    (flag_q[g])
    );
  end

  assign chg_irq_o     = flag_q[FLAG_CHG];
  assign resume_flag_o = flag_q[FLAG_RES];

  p_disabled_no_chg_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_reset_i && !en_addr_i && !en_cfg_i && !en_susp_i && !chg_irq_o) |=> !chg_irq_o);

  p_reset_beats_susp_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_reset_i && suspend_i) |=> state_o == 3'b001);
endmodule

// File: tb/usb_dev_state_trk_test.sv
module usb_dev_state_trk_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_reset, suspend, resume, set_addr, addr_zero, set_cfg, cfg_zero;
  logic en_reset, en_addr, en_cfg, en_susp, clr_chg, clr_resume;
  logic [2:0] state;
  logic chg_irq, resume_flag;

  int total = 0;
  int bad = 0;
  logic [2:0] m_state;
  logic m_chg, m_res;
  string tag;

  always #10 clk = ~clk;

  usb_dev_state_trk uut (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_reset_i(bus_reset), .suspend_i(suspend), .resume_i(resume),
    .set_addr_i(set_addr), .addr_zero_i(addr_zero),
    .set_cfg_i(set_cfg), .cfg_zero_i(cfg_zero),
    .en_reset_i(en_reset), .en_addr_i(en_addr), .en_cfg_i(en_cfg), .en_susp_i(en_susp),
    .clr_chg_i(clr_chg), .clr_resume_i(clr_resume),
    .state_o(state), .chg_irq_o(chg_irq), .resume_flag_o(resume_flag)
  );

  task automatic check(input string t, input logic [2:0] s, input logic c, input logic r);
    total++;
    if (state !== s || chg_irq !== c || resume_flag !== r) begin
      bad++;
      $display("FAIL %s: state=%b chg=%b res=%b expected state=%b chg=%b res=%b",
               t, state, chg_irq, resume_flag, s, c, r);
    end
  endtask

  task automatic idle();
    {bus_reset, suspend, resume, set_addr, addr_zero, set_cfg, cfg_zero} = '0;
    {clr_chg, clr_resume} = '0;
  endtask

  // reference model, one cycle
  task automatic model_step();
    logic cs, rs;
    logic [2:0] ns;
    cs = 1'b0; rs = 1'b0; ns = m_state; tag = "R11 ignored";
    if (bus_reset) begin
      ns = 3'b001; cs = en_reset; tag = suspend ? "R12 reset wins" : "R3 bus reset";
    end else if (m_state[2]) begin
      if (resume) begin ns = {1'b0, m_state[1:0]}; rs = 1'b1; tag = "R9 resume"; end
    end else if (suspend) begin
      ns = {1'b1, m_state[1:0]}; cs = en_susp; tag = "R8 suspend";
    end else if (set_addr && !addr_zero && m_state == 3'b001) begin
      ns = 3'b010; cs = en_addr; tag = "R4 set addr";
    end else if (set_addr && addr_zero && m_state == 3'b010) begin
      ns = 3'b001; cs = en_reset; tag = "R5 addr zero";
    end else if (set_cfg && !cfg_zero && m_state == 3'b010) begin
      ns = 3'b011; cs = en_cfg; tag = "R6 set cfg";
    end else if (set_cfg && cfg_zero && m_state == 3'b011) begin
      ns = 3'b010; cs = en_addr; tag = "R7 cfg zero";
    end
    if ((clr_chg && !cs && m_chg) || (clr_resume && !rs && m_res)) tag = {tag, " R13 clear"};
    m_chg = cs | (m_chg & ~clr_chg);
    m_res = rs | (m_res & ~clr_resume);
    m_state = ns;
  endtask

  // drive at negedge, one posedge, sample at next negedge
  task automatic step();
    model_step();
    @(posedge clk);
    @(negedge clk);
    check(tag, m_state, m_chg, m_res);
    idle();
  endtask

  initial begin
    #3_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    idle();
    {en_reset, en_addr, en_cfg, en_susp} = 4'b1111;
    m_state = 3'b000; m_chg = 1'b0; m_res = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset state", 3'b000, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", 3'b000, 1'b0, 1'b0);

    // directed walk: R2 codes, R4, R6, R8, R9
    set_addr = 1'b1; step();                      // R11 ignored in powered
    suspend = 1'b1; step();                       // 100
    clr_chg = 1'b1; resume = 1'b1; step();        // 000, res set
    bus_reset = 1'b1; step();                     // 001
    set_addr = 1'b1; step();                      // 010
    set_cfg = 1'b1; step();                       // 011
    suspend = 1'b1; step();                       // R2 111
    set_cfg = 1'b1; cfg_zero = 1'b1; step();      // R11 ignored while suspended
    resume = 1'b1; step();                        // 011
    resume = 1'b1; step();                        // R11 resume not suspended
    // R10 enables off, transitions still happen
    {en_reset, en_addr, en_cfg, en_susp} = 4'b0000;
    clr_chg = 1'b1; clr_resume = 1'b1; step();
    set_cfg = 1'b1; cfg_zero = 1'b1; step();      // R7 -> 010, no flag
    set_addr = 1'b1; addr_zero = 1'b1; step();    // R5 -> 001, no flag
    // R12 collision, R13 set beats clear
    en_reset = 1'b1;
    bus_reset = 1'b1; suspend = 1'b1; clr_chg = 1'b1; step();
    set_addr = 1'b1; set_cfg = 1'b1; en_addr = 1'b1; step(); // R12 addr first -> 010
    suspend = 1'b1; set_cfg = 1'b1; step();       // R12 suspend beats cfg -> 110
    clr_chg = 1'b1; step();

    for (int i = 0; i < 4000; i++) begin
      bus_reset  = ($urandom_range(0, 29) == 0);
      suspend    = ($urandom_range(0, 7) == 0);
      resume     = ($urandom_range(0, 5) == 0);
      set_addr   = ($urandom_range(0, 3) == 0);
      addr_zero  = ($urandom_range(0, 2) == 0);
      set_cfg    = ($urandom_range(0, 3) == 0);
      cfg_zero   = ($urandom_range(0, 2) == 0);
      en_reset   = $urandom_range(0, 1) == 1;
      en_addr    = $urandom_range(0, 1) == 1;
      en_cfg     = $urandom_range(0, 1) == 1;
      en_susp    = $urandom_range(0, 1) == 1;
      clr_chg    = ($urandom_range(0, 3) == 0);
      clr_resume = ($urandom_range(0, 3) == 0);
      step();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule